// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Meter

This block counts how many ticks of a selected target clock fall between two qualifying edges of an asynchronous reference signal. All target clocks arrive as single-cycle enable pulses in the one system clock domain. A prescaler thins the selected tick stream before it reaches a saturating 16-bit counter. On each qualifying reference edge the counter value is latched into a capture register, a one-cycle valid strobe is raised, and the counter starts again from zero.

An 8-bit configuration register chooses the target source, the prescale ratio, the qualifying reference edge, and whether the reference is looked at at all. A separate measurement-enable input starts and stops the run. The register can only be loaded while measurement is stopped. Because the prescaler and counter restart from zero whenever a run starts, the first window after enabling is partial and is thrown away.

Top module: `refclk_meter`

## Requirements
- R1: After reset, `ctrlOut` is 0x00, `capValid` is 0, `capCount` is 0, `capOverflow` is 0 and `overflowFlag` is 0.
- R2: A write through `cfgWrEn`/`cfgWrData` loads the register only while `measEn` is 0; writes while `measEn` is 1 leave `ctrlOut` unchanged. Bit 0 is the reference enable, bits 3:1 the target select, bits 5:4 the prescale code and bits 7:6 the edge code.
- R3: Target codes 0 to 5 select line `tgtTick[code]`; pulses on the other lines are not counted.
- R4: Prescale code 00 counts every selected tick, 01 every 4th, 10 every 8th and 11 every 32nd. The prescaler phase carries over from one window to the next and restarts only when a run starts.
- R5: Edge code 00 qualifies rising reference edges, 01 falling edges and 10 both edges.
- R6: With target code 6 or 7, or with edge code 11, no capture is produced and the counter stays at zero.
- R7: When bit 0 of the register is 0, reference edges produce no capture.
- R8: The first qualifying edge after `measEn` rises only restarts the counter. It produces no capture.
- R9: Each later qualifying edge puts the count of prescaled ticks since the previous qualifying edge on `capCount`, pulses `capValid` for one cycle, and restarts the counter from zero.
- R10: The counter stops at 65535. A prescaled tick that arrives at that value sets `overflowFlag`, which stays set until the next qualifying edge clears it. At a capture, `capOverflow` shows the flag's value just before the edge.
- R11: `capValid` goes high on the third rising clock edge after a qualifying change of `refIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write value |
| measEn | input | 1 | Measurement run enable |
| tgtTick | input | 6 | Target clock enable pulses, one per source |
| refIn | input | 1 | Asynchronous reference signal |
| ctrlOut | output | 8 | Current configuration register value |
| capCount | output | 16 | Latched count of the last complete window |
| capValid | output | 1 | One-cycle strobe that marks a new capture |
| capOverflow | output | 1 | Overflow state of the captured window |
| overflowFlag | output | 1 | Sticky overflow of the window now being counted |

## Verification
A prescaler phase that fails to carry over, or that restarts at the wrong moment, makes `capCount` differ by one from the count of whole divided ticks. This error appears at the next capture, three clock edges after the reference edge. A priming flag that is not cleared when a run starts lets a partial window reach `capValid` and shifts every later capture by one entry. A qualifier that accepts the wrong edge, a prohibited code or a disabled reference produces an extra strobe or a missing strobe within three cycles of that edge. A register that takes writes during a run shows up at once on `ctrlOut`.

// File: rtl/refclk_meter_pkg.sv
package refclk_meter_pkg;

  localparam int NUM_TGT = 6;
  localparam int TSEL_W  = 3;
  localparam int CFG_W   = 8;
  localparam int PHASE_W = 5;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_BAD  = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic run;      // measurement active with a legal configuration
    logic restart;  // qualifying reference edge seen
    logic capture;  // qualifying edge that closes a complete window
  } meter_stb_t;

  function automatic logic [PHASE_W-1:0] lastPhase(input logic [1:0] preSel);
    case (preSel)
      2'b00:   lastPhase = PHASE_W'(0);
      2'b01:   lastPhase = PHASE_W'(3);
      2'b10:   lastPhase = PHASE_W'(7);
      default: lastPhase = PHASE_W'(31);
    endcase
  endfunction

endpackage

// File: rtl/refclk_meter_ctrl.sv
module refclk_meter_ctrl
  import refclk_meter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              measEn,
  input  logic              refIn,
  output logic [CFG_W-1:0]  ctrlQ,
  output logic [TSEL_W-1:0] tgtSel,
  output logic [1:0]        preSel,
  output meter_stb_t        stb
);

  logic [CFG_W-1:0] ctrlReg;
  logic             refNow;
  logic             refPrev;
  logic             primed;
  logic             refEnable;
  edge_mode_e       edgeSel;
  logic             cfgLegal;
  logic             edgeHit;
  logic             run;
  logic             validEdge;

  // configuration register, frozen while a run is active
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    ctrlReg <= '0;
    else if (cfgWrEn && !measEn)  ctrlReg <= cfgWrData;
  end

  // reference synchronizer
  generate
    if (SYNC_STAGES <= 1) begin : gSyncOne
      logic syncFf;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncFf <= 1'b0;
        else       syncFf <= refIn;
      end
      assign refNow = syncFf;
    end else begin : gSyncChain
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], refIn};
      end
      assign refNow = syncChain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refPrev <= 1'b0;
    else       refPrev <= refNow;
  end

  assign refEnable = ctrlReg[0];
  assign tgtSel    = ctrlReg[3:1];
  assign preSel    = ctrlReg[5:4];
  assign edgeSel   = edge_mode_e'(ctrlReg[7:6]);
  assign cfgLegal  = (tgtSel < TSEL_W'(NUM_TGT)) && (edgeSel != EDGE_BAD);

  always_comb begin
    case (edgeSel)
      EDGE_RISE: edgeHit = refNow & ~refPrev;
      EDGE_FALL: edgeHit = ~refNow & refPrev;
      EDGE_BOTH: edgeHit = refNow ^ refPrev;
      default:   edgeHit = 1'b0;
    endcase
  end

  assign run       = measEn & cfgLegal;
  assign validEdge = run & refEnable & edgeHit;

  // first qualifying edge of a run only arms the capture path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          primed <= 1'b0;
    else if (!run)      primed <= 1'b0;
    else if (validEdge) primed <= 1'b1;
  end

  assign ctrlQ       = ctrlReg;
  assign stb.run     = run;
  assign stb.restart = validEdge;
  assign stb.capture = validEdge & primed;

endmodule

// File: rtl/refclk_meter_dp.sv
module refclk_meter_dp
  import refclk_meter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  meter_stb_t        stb,
  input  logic [NUM_TGT-1:0] tgtTick,
  input  logic [TSEL_W-1:0] tgtSel,
  input  logic [1:0]        preSel,
  output logic [CNT_W-1:0]  capCount,
  output logic              capValid,
  output logic              capOverflow,
  output logic              overflowFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic               srcTick;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] phaseEnd;
  logic               preTick;
  logic [CNT_W-1:0]   cnt;
  logic               ovf;

  // target source mux
  always_comb begin
    srcTick = 1'b0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (tgtSel == TSEL_W'(i)) srcTick = tgtTick[i];
    end
  end

  // prescaler
  assign phaseEnd = lastPhase(preSel);
  assign preTick  = srcTick && (phase == phaseEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             phase <= '0;
    else if (!stb.run)     phase <= '0;
    else if (srcTick) begin
      if (phase == phaseEnd) phase <= '0;
      else                   phase <= phase + 1'b1;
    end
  end

  // saturating window counter with sticky overflow
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (!stb.run || stb.restart) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (preTick) begin
      if (cnt == CNT_MAX) ovf <= 1'b1;
      else                cnt <= cnt + 1'b1;
    end
  end

  // capture registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capCount    <= '0;
      capOverflow <= 1'b0;
      capValid    <= 1'b0;
    end else begin
      capValid <= stb.capture;
      if (stb.capture) begin
        capCount    <= cnt;
        capOverflow <= ovf;
      end
    end
  end

  assign overflowFlag = ovf;

endmodule

// File: rtl/refclk_meter.sv
module refclk_meter
  import refclk_meter_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic [7:0]   cfgWrData,
  input  logic         measEn,
  input  logic [5:0]   tgtTick,
  input  logic         refIn,
  output logic [7:0]   ctrlOut,
  output logic [15:0]  capCount,
  output logic         capValid,
  output logic         capOverflow,
  output logic         overflowFlag
);

  meter_stb_t        stb;
  logic [TSEL_W-1:0] tgtSel;
  logic [1:0]        preSel;
  logic [CNT_W-1:0]  capCountInt;

  refclk_meter_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .measEn    (measEn),
    .refIn     (refIn),
    .ctrlQ     (ctrlOut),
    .tgtSel    (tgtSel),
    .preSel    (preSel),
    .stb       (stb)
  );

  refclk_meter_dp #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .tgtTick      (tgtTick),
    .tgtSel       (tgtSel),
    .preSel       (preSel),
    .capCount     (capCountInt),
    .capValid     (capValid),
    .capOverflow  (capOverflow),
    .overflowFlag (overflowFlag)
  );

  assign capCount = 16'(capCountInt);

endmodule

// File: rtl/refclk_meter_chk.sv
module refclk_meter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       measEn,
  input logic [7:0] ctrlOut,
  input logic       capValid,
  input logic       overflowFlag
);

  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rstN)
    measEn |=> $stable(ctrlOut));

  assert_bad_cfg_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlOut[3:1] > 3'd5) || (ctrlOut[7:6] == 2'b11)) |=> !capValid);

  assert_ref_off_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOut[0] |=> !capValid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !measEn |=> !capValid);

  assert_ovf_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    capValid |-> !overflowFlag);

endmodule

bind refclk_meter refclk_meter_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .measEn       (measEn),
  .ctrlOut      (ctrlOut),
  .capValid     (capValid),
  .overflowFlag (overflowFlag)
);

// File: tb/refclk_meter_bench.sv
`timescale 1ns/1ps
module refclk_meter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic        measEn = 1'b0;
  logic [5:0]  tgtTick = '0;
  logic        refIn = 1'b0;
  logic [7:0]  ctrlOut;
  logic [15:0] capCount;
  logic        capValid;
  logic        capOverflow;
  logic        overflowFlag;

  always #2.5 clk = ~clk;

  refclk_meter u_refclk_meter (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .measEn(measEn), .tgtTick(tgtTick), .refIn(refIn), .ctrlOut(ctrlOut),
    .capCount(capCount), .capValid(capValid), .capOverflow(capOverflow),
    .overflowFlag(overflowFlag)
  );

  int checks = 0;
  int errors = 0;
  int capSeen = 0;
  int cycles = 0;
  logic [16:0] expQ[$];
  string curReq = "R1";

  // reference model state
  logic [7:0] mCfg = '0;
  bit mEn = 0, mRef = 0, mPrimed = 0, mOvf = 0;
  int mPhase = 0, mCnt = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int divOf(logic [1:0] c);
    case (c) 2'b00: return 1; 2'b01: return 4; 2'b10: return 8; default: return 32; endcase
  endfunction

  function automatic bit mRun();
    return mEn && (mCfg[3:1] <= 3'd5) && (mCfg[7:6] != 2'b11);
  endfunction

  // monitor: pops expected captures as the design produces them
  bit prevCap = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevCap) begin
        checks++;
        if (capValid) begin
          errors++;
          $display("FAIL R9: capValid width actual >1 expected 1");
        end
      end
      if (capValid) begin
        capSeen++;
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL %s: unexpected capture actual %0d expected none", curReq, capCount);
        end else begin
          logic [16:0] e;
          e = expQ.pop_front();
          if ({capOverflow, capCount} !== e) begin
            errors++;
            $display("FAIL %s: capture actual %0d/%0d expected %0d/%0d",
                     curReq, capCount, capOverflow, e[15:0], e[16]);
          end
        end
      end
      prevCap = capValid;
    end
  end

  task automatic wrCfg(logic [7:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
    if (!mEn) mCfg = v;
  endtask

  task automatic setEn(bit v);
    @(negedge clk); measEn = v;
    mEn = v; mPhase = 0; mCnt = 0; mOvf = 0; mPrimed = 0;
    @(negedge clk);
  endtask

  task automatic ticks(int idx, int n, bit noise);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tgtTick = 6'(1 << idx) | (noise ? 6'(1 << ((idx + 1) % 6)) : 6'd0);
      if (mRun() && mCfg[3:1] == 3'(idx)) begin
        mPhase++;
        if (mPhase == divOf(mCfg[5:4])) begin
          mPhase = 0;
          if (mCnt == 65535) mOvf = 1; else mCnt++;
        end
      end
    end
    @(negedge clk); tgtTick = '0;
  endtask

  task automatic refEdge(bit lvl, string req);
    bit rise, fall, hit, valid, expectCap;
    rise = lvl && !mRef;
    fall = !lvl && mRef;
    case (mCfg[7:6])
      2'b00: hit = rise; 2'b01: hit = fall; 2'b10: hit = rise || fall; default: hit = 0;
    endcase
    valid = mRun() && mCfg[0] && hit;
    expectCap = valid && mPrimed;
    curReq = req;
    if (expectCap) expQ.push_back({mOvf, 16'(mCnt)});
    if (valid) begin mPrimed = 1; mCnt = 0; mOvf = 0; end
    mRef = lvl;
    @(negedge clk); refIn = lvl;
    @(negedge clk); @(negedge clk);
    if (expectCap) chk("R11 early", int'(capValid), 0);
    @(negedge clk);
    if (expectCap) chk("R11 on time", int'(capValid), 1);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    while (1) begin
      @(posedge clk); cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seen;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ctrl", int'(ctrlOut), 0);
    chk("R1 capValid", int'(capValid), 0);
    chk("R1 capCount", int'(capCount), 0);
    chk("R1 capOverflow", int'(capOverflow), 0);
    chk("R1 overflowFlag", int'(overflowFlag), 0);

    // R2 R3 R5 R8 R9: rising edges, target 2, no prescale
    wrCfg(8'h05);
    chk("R2 write", int'(ctrlOut), 8'h05);
    setEn(1);
    refEdge(1, "R8");            // primes only
    ticks(2, 10, 1);             // R3 noise on line 3
    refEdge(0, "R5");            // falling ignored
    ticks(2, 5, 1);
    refEdge(1, "R9");            // expect 15
    ticks(2, 7, 0);
    ticks(3, 4, 0);              // R3 other line only
    refEdge(0, "R5");
    refEdge(1, "R9");            // expect 7

    wrCfg(8'hFF);
    chk("R2 frozen", int'(ctrlOut), 8'h05);

    // R4 divide by 4, R5 falling, target 5
    setEn(0);
    wrCfg(8'h5B);
    chk("R2 fields", int'(ctrlOut), 8'h5B);
    setEn(1);
    refEdge(0, "R8");
    ticks(5, 10, 0);
    refEdge(1, "R5");
    refEdge(0, "R4");            // expect 2
    ticks(5, 9, 1);
    refEdge(1, "R5");
    refEdge(0, "R4");            // expect 2 (phase carried)

    // R4 divide by 8, both edges, target 0
    setEn(0);
    wrCfg(8'hA1);
    setEn(1);
    refEdge(1, "R8");
    ticks(0, 20, 1);
    refEdge(0, "R5");
    ticks(0, 13, 0);
    refEdge(1, "R4");

    // R4 divide by 32, rising, target 4
    setEn(0);
    wrCfg(8'h39);
    setEn(1);
    refEdge(0, "R8");
    refEdge(1, "R8");
    ticks(4, 70, 0);
    refEdge(0, "R5");
    refEdge(1, "R4");

    // R7 reference disabled
    setEn(0);
    wrCfg(8'h02);
    setEn(1);
    seen = capSeen;
    for (int j = 0; j < 3; j++) begin
      refEdge(0, "R7"); ticks(1, 6, 0); refEdge(1, "R7");
    end
    chk("R7 no capture", capSeen - seen, 0);

    // R6 prohibited target code
    setEn(0);
    wrCfg(8'h0D);
    setEn(1);
    seen = capSeen;
    for (int j = 0; j < 3; j++) begin
      refEdge(0, "R6"); ticks(0, 6, 1); refEdge(1, "R6");
    end
    chk("R6 bad target", capSeen - seen, 0);
    chk("R6 ovf idle", int'(overflowFlag), 0);

    // R6 prohibited edge code
    setEn(0);
    wrCfg(8'hC1);
    setEn(1);
    seen = capSeen;
    for (int j = 0; j < 3; j++) begin
      refEdge(0, "R6"); ticks(0, 6, 0); refEdge(1, "R6");
    end
    chk("R6 bad edge", capSeen - seen, 0);

    // R10 saturation and sticky overflow
    setEn(0);
    wrCfg(8'h01);
    setEn(1);
    refEdge(0, "R8");
    refEdge(1, "R8");
    ticks(0, 100, 0);
    chk("R10 not yet", int'(overflowFlag), 0);
    ticks(0, 65440, 0);
    chk("R10 sticky", int'(overflowFlag), 1);
    refEdge(0, "R10");
    refEdge(1, "R10");           // expect 65535 with overflow
    chk("R10 cleared", int'(overflowFlag), 0);
    ticks(0, 3, 0);
    refEdge(0, "R10");
    refEdge(1, "R10");           // expect 3, no overflow

    setEn(0);
    repeat (4) @(negedge clk);
    chk("R9 queue drained", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule